// File: doc/BRIEF.md
# USB Device Endpoint Event Flag Aggregator

This block keeps the per-endpoint event flags of a USB device controller for a configurable number of OUT and IN endpoints (eight of each by default). The controller core reports events as single-cycle pulses. Each pulse sets a sticky flag, and software clears the flag by writing a one to it. Events are transfer complete, endpoint disabled, end of a SETUP stage, a long run of back-to-back SETUP packets, an OUT token hitting a disabled endpoint, and an IN token timeout. Every endpoint's flags OR into one bit of a summary word, and each half of the summary word ORs into a global OUT or IN interrupt line. A flag clear therefore also drops the endpoint's summary bit and, once nothing else is pending, the global line.

Only the endpoints named in the `CTRL_EP_MASK` parameter are control endpoints. Only these endpoints track SETUP runs, flag OUT tokens that arrive while the endpoint is disabled, and flag IN timeouts. For the other endpoints these inputs are ignored and the related flag bits read as zero. Access is through a simple single-cycle register port. Reads are combinational, and a write acts as a write-one-to-clear on the selected endpoint word.

Top module: `usb_ep_evt_agg`

## Requirements
- R1: While reset is asserted and right after it, every endpoint word and the summary word read zero, and both global interrupt outputs are low.
- R2: An event pulse sets its flag at the next clock edge. The OUT word uses bit 0 for transfer complete and bit 1 for endpoint disabled. The IN word uses bit 0 for transfer complete, bit 1 for endpoint disabled and bit 3 for IN timeout, and bit 3 is set only on control endpoints.
- R3: A write with a 1 in a flag position clears that flag at the next edge. A 0 leaves the flag unchanged. Bits that hold no flag (OUT bits 2, 5 and 7..31; IN bits 2 and 4..31) always read zero.
- R4: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set. Other bits in the same write are still cleared.
- R5: Summary bit i is the OR of IN endpoint i's flags, and summary bit 16+i is the OR of OUT endpoint i's flags. `irq_in_ep_o` and `irq_out_ep_o` are the OR of those halves. Clearing an endpoint's last flag drops its summary bit and, when nothing else is pending, the global line.
- R6: On a control OUT endpoint, OUT bit 3 (SETUP stage done) is set only when a non-SETUP token (OUT or IN) arrives after one or more SETUP packets. It is not set while SETUP packets are still arriving.
- R7: On a control OUT endpoint, OUT bit 6 is set by the fourth SETUP packet in a row. Any non-SETUP token restarts the count.
- R8: On a control OUT endpoint, OUT bit 4 is set when an OUT token arrives while that endpoint's enable input is low. It is not set when the endpoint is enabled or is not a control endpoint.
- R9: On non-control endpoints, SETUP pulses, tokens and timeout pulses change no register.
- R10: Word address i (0..7) selects OUT endpoint i, address 8+i selects IN endpoint i, and address 16 selects the read-only summary word. Writes to the summary word or to unmapped addresses have no effect, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_xfer_i | input | NUM_EP | Per-endpoint OUT transfer-complete pulse |
| out_dis_i | input | NUM_EP | Per-endpoint OUT endpoint-disabled pulse |
| out_setup_i | input | NUM_EP | Per-endpoint SETUP packet received pulse |
| out_tok_i | input | NUM_EP | Per-endpoint OUT token pulse |
| in_tok_i | input | NUM_EP | Per-endpoint IN token pulse |
| out_ep_en_i | input | NUM_EP | Per-endpoint OUT enable level |
| in_xfer_i | input | NUM_EP | Per-endpoint IN transfer-complete pulse |
| in_dis_i | input | NUM_EP | Per-endpoint IN endpoint-disabled pulse |
| in_tmo_i | input | NUM_EP | Per-endpoint IN token timeout pulse |
| reg_wr_i | input | 1 | Write strobe (write-one-to-clear) |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_out_ep_o | output | 1 | Some OUT endpoint flag pending |
| irq_in_ep_o | output | 1 | Some IN endpoint flag pending |

## Verification
Every flag is one register stage from its cause. A pulse or write driven in cycle n is visible on `reg_rdata_o`, the summary word and the interrupt lines after the edge that ends cycle n. The summary and interrupt paths add no extra stage, and reads are combinational in the address. The bench drives inputs on the falling edge and holds each pulse for one cycle. It samples reads a short delay after setting the address on a later falling edge, so every comparison lands after the single register stage has updated. SETUP-run checks read the flags after each pulse, to confirm that neither the done flag nor the back-to-back flag appears one packet early.

// File: rtl/usb_ep_evt_pkg.sv
package usb_ep_evt_pkg;
   localparam int unsigned REG_W        = 32;
   localparam int unsigned FLAG_W       = 7;
   localparam int unsigned OUT_SUM_BASE = 16;
   // OUT word bit positions
   localparam int unsigned OB_XFER  = 0;
   localparam int unsigned OB_DIS   = 1;
   localparam int unsigned OB_SDONE = 3;
   localparam int unsigned OB_TOKD  = 4;
   localparam int unsigned OB_B2B   = 6;
   // IN word bit positions
   localparam int unsigned IB_XFER  = 0;
   localparam int unsigned IB_DIS   = 1;
   localparam int unsigned IB_TMO   = 3;

   function automatic logic [FLAG_W-1:0] out_mask(input bit is_ctrl);
      logic [FLAG_W-1:0] m;
      m = '0;
      m[OB_XFER] = 1'b1;
      m[OB_DIS]  = 1'b1;
      if (is_ctrl) begin
         m[OB_SDONE] = 1'b1;
         m[OB_TOKD]  = 1'b1;
         m[OB_B2B]   = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [FLAG_W-1:0] in_mask(input bit is_ctrl);
      logic [FLAG_W-1:0] m;
      m = '0;
      m[IB_XFER] = 1'b1;
      m[IB_DIS]  = 1'b1;
      if (is_ctrl) m[IB_TMO] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/usb_w1c_bank.sv
module usb_w1c_bank #(
   parameter int unsigned W    = 7,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK[b]) begin : g_flop
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_i[b]) | set_i[b];
         end
         assign q_o[b] = q;

         a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> q_o[b]);
         a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !q_o[b]);
         a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[b] && !set_i[b]) |=> $stable(q_o[b]));
         a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && set_i[b]) |=> q_o[b]);
      end else begin : g_none
         assign q_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/usb_setup_run.sv
module usb_setup_run #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic setup_i,
   input  logic tok_i,
   output logic done_o,
   output logic b2b_o
);
   localparam int unsigned SAT   = LIMIT + 1;
   localparam int unsigned CNT_W = $clog2(SAT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("usb_setup_run: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic             end_run;

   assign end_run = tok_i & ~setup_i;
   assign done_o  = end_run & pend;
   assign b2b_o   = setup_i & (cnt == CNT_W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (setup_i) begin
         pend <= 1'b1;
         if (cnt != CNT_W'(SAT)) cnt <= cnt + 1'b1;
      end else if (tok_i) begin
         pend <= 1'b0;
         cnt  <= '0;
      end
   end

   a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(SAT));
   a_r7_tok_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      end_run |=> (cnt == '0) && !pend);
   a_r6_done_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(pend) || $past(setup_i));
endmodule

// File: rtl/usb_out_ep.sv
module usb_out_ep
   import usb_ep_evt_pkg::*;
#(
   parameter bit          IS_CTRL   = 1'b0,
   parameter int unsigned B2B_LIMIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_i,
   input  logic             dis_i,
   input  logic             setup_i,
   input  logic             out_tok_i,
   input  logic             in_tok_i,
   input  logic             ep_en_i,
   input  logic             clr_sel_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] word_o
);
   localparam logic [FLAG_W-1:0] MASK = out_mask(IS_CTRL);

   logic [FLAG_W-1:0] set_v, clr_v, flags;
   logic              sdone, b2b, tokd;

   if (IS_CTRL) begin : g_ctrl
      usb_setup_run #(.LIMIT(B2B_LIMIT)) i_run (
         .clk    (clk),
         .rst_n  (rst_n),
         .setup_i(setup_i),
         .tok_i  (out_tok_i | in_tok_i),
         .done_o (sdone),
         .b2b_o  (b2b)
      );
      assign tokd = out_tok_i & ~ep_en_i;
   end else begin : g_plain
      assign sdone = 1'b0;
      assign b2b   = 1'b0;
      assign tokd  = 1'b0;
   end

   always_comb begin
      set_v           = '0;
      set_v[OB_XFER]  = xfer_i;
      set_v[OB_DIS]   = dis_i;
      set_v[OB_SDONE] = sdone;
      set_v[OB_TOKD]  = tokd;
      set_v[OB_B2B]   = b2b;
      clr_v           = clr_sel_i ? wdata_i[FLAG_W-1:0] : '0;
   end

   usb_w1c_bank #(.W(FLAG_W), .MASK(MASK)) i_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v),
      .clr_i(clr_v),
      .q_o  (flags)
   );

   assign word_o = {{(REG_W-FLAG_W){1'b0}}, flags};

   a_r8_tokd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_o[OB_TOKD]) |-> $past(out_tok_i) && !$past(ep_en_i));
   a_r6_sdone_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_o[OB_SDONE]) |-> $past(out_tok_i || in_tok_i) && !$past(setup_i));
   a_r7_b2b_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_o[OB_B2B]) |-> $past(setup_i));
endmodule

// File: rtl/usb_in_ep.sv
module usb_in_ep
   import usb_ep_evt_pkg::*;
#(
   parameter bit IS_CTRL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_i,
   input  logic             dis_i,
   input  logic             tmo_i,
   input  logic             clr_sel_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] word_o
);
   localparam logic [FLAG_W-1:0] MASK = in_mask(IS_CTRL);

   logic [FLAG_W-1:0] set_v, clr_v, flags;

   always_comb begin
      set_v          = '0;
      set_v[IB_XFER] = xfer_i;
      set_v[IB_DIS]  = dis_i;
      set_v[IB_TMO]  = tmo_i;
      clr_v          = clr_sel_i ? wdata_i[FLAG_W-1:0] : '0;
   end

   usb_w1c_bank #(.W(FLAG_W), .MASK(MASK)) i_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v),
      .clr_i(clr_v),
      .q_o  (flags)
   );

   assign word_o = {{(REG_W-FLAG_W){1'b0}}, flags};

   a_r9_tmo_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_o[IB_TMO]) |-> $past(tmo_i));
endmodule

// File: rtl/usb_ep_evt_agg.sv
module usb_ep_evt_agg
   import usb_ep_evt_pkg::*;
#(
   parameter int unsigned    NUM_EP       = 8,
   parameter int unsigned    ADDR_W       = 5,
   parameter int unsigned    B2B_LIMIT    = 3,
   parameter logic [NUM_EP-1:0] CTRL_EP_MASK = NUM_EP'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] out_xfer_i,
   input  logic [NUM_EP-1:0] out_dis_i,
   input  logic [NUM_EP-1:0] out_setup_i,
   input  logic [NUM_EP-1:0] out_tok_i,
   input  logic [NUM_EP-1:0] in_tok_i,
   input  logic [NUM_EP-1:0] out_ep_en_i,
   input  logic [NUM_EP-1:0] in_xfer_i,
   input  logic [NUM_EP-1:0] in_dis_i,
   input  logic [NUM_EP-1:0] in_tmo_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              irq_out_ep_o,
   output logic              irq_in_ep_o
);
   localparam int unsigned IN_BASE  = NUM_EP;
   localparam int unsigned SUM_ADDR = 2 * NUM_EP;

   if (NUM_EP < 1 || NUM_EP > OUT_SUM_BASE) begin : g_bad_ep
      $error("usb_ep_evt_agg: NUM_EP must be 1..16");
   end
   if ((SUM_ADDR + 1) > (1 << ADDR_W)) begin : g_bad_addr
      $error("usb_ep_evt_agg: ADDR_W too narrow for the map");
   end

   logic [REG_W-1:0]  out_word [NUM_EP];
   logic [REG_W-1:0]  in_word  [NUM_EP];
   logic [REG_W-1:0]  sum_word;
   logic [NUM_EP-1:0] out_any, in_any;

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic out_sel, in_sel;
      assign out_sel = reg_wr_i && (reg_addr_i == ADDR_W'(e));
      assign in_sel  = reg_wr_i && (reg_addr_i == ADDR_W'(IN_BASE + e));

      usb_out_ep #(.IS_CTRL(CTRL_EP_MASK[e]), .B2B_LIMIT(B2B_LIMIT)) i_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .xfer_i   (out_xfer_i[e]),
         .dis_i    (out_dis_i[e]),
         .setup_i  (out_setup_i[e]),
         .out_tok_i(out_tok_i[e]),
         .in_tok_i (in_tok_i[e]),
         .ep_en_i  (out_ep_en_i[e]),
         .clr_sel_i(out_sel),
         .wdata_i  (reg_wdata_i),
         .word_o   (out_word[e])
      );

      usb_in_ep #(.IS_CTRL(CTRL_EP_MASK[e])) i_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .xfer_i   (in_xfer_i[e]),
         .dis_i    (in_dis_i[e]),
         .tmo_i    (in_tmo_i[e]),
         .clr_sel_i(in_sel),
         .wdata_i  (reg_wdata_i),
         .word_o   (in_word[e])
      );

      assign out_any[e] = |out_word[e];
      assign in_any[e]  = |in_word[e];
   end

   always_comb begin
      sum_word = '0;
      for (int e = 0; e < NUM_EP; e++) begin
         sum_word[e]                = in_any[e];
         sum_word[OUT_SUM_BASE + e] = out_any[e];
      end
   end

   assign irq_out_ep_o = |out_any;
   assign irq_in_ep_o  = |in_any;

   always_comb begin
      reg_rdata_o = '0;
      for (int e = 0; e < NUM_EP; e++) begin
         if (reg_addr_i == ADDR_W'(e))           reg_rdata_o = out_word[e];
         if (reg_addr_i == ADDR_W'(IN_BASE + e)) reg_rdata_o = in_word[e];
      end
      if (reg_addr_i == ADDR_W'(SUM_ADDR)) reg_rdata_o = sum_word;
   end

   logic any_evt;
   assign any_evt = |{out_xfer_i, out_dis_i, out_setup_i, out_tok_i, in_tok_i,
                      in_xfer_i, in_dis_i, in_tmo_i};

   a_r10_sum_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i >= ADDR_W'(SUM_ADDR) && !any_evt) |=> $stable(sum_word));
   a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out_ep_o) |-> $past(reg_wr_i));
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> !irq_out_ep_o && !irq_in_ep_o);
endmodule

// File: tb/test_usb_ep_evt_agg.sv
`timescale 1ns/1ps
module test_usb_ep_evt_agg;
   localparam int NE = 8;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [NE-1:0] out_xfer, out_dis, out_setup, out_tok, in_tok, ep_en, in_xfer, in_dis, in_tmo;
   logic reg_wr;
   logic [4:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic irq_out, irq_in;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [31:0] exp_out [NE];
   logic [31:0] exp_in  [NE];

   always #2.5 clk = ~clk;

   usb_ep_evt_agg i_usb_ep_evt_agg (
      .clk(clk), .rst_n(rst_n),
      .out_xfer_i(out_xfer), .out_dis_i(out_dis), .out_setup_i(out_setup),
      .out_tok_i(out_tok), .in_tok_i(in_tok), .out_ep_en_i(ep_en),
      .in_xfer_i(in_xfer), .in_dis_i(in_dis), .in_tmo_i(in_tmo),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .irq_out_ep_o(irq_out), .irq_in_ep_o(irq_in));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic check_all(input string req);
      logic [31:0] d, s;
      s = 0;
      for (int e = 0; e < NE; e++) begin
         rd(5'(e), d);      chk(req, $sformatf("out%0d", e), d, exp_out[e]);
         rd(5'(NE + e), d); chk(req, $sformatf("in%0d", e), d, exp_in[e]);
         s[e]      = (exp_in[e]  != 0);
         s[16 + e] = (exp_out[e] != 0);
      end
      rd(5'd16, d);
      chk("R5", "summary", d, s);
      chk("R5", "irq_out", {31'd0, irq_out}, {31'd0, |s[23:16]});
      chk("R5", "irq_in",  {31'd0, irq_in},  {31'd0, |s[7:0]});
   endtask

   // kind: 0 out_xfer 1 out_dis 2 setup 3 out_tok 4 in_tok 5 in_xfer 6 in_dis 7 in_tmo
   task automatic fire(input int kind, input int ep, input bit wr, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      case (kind)
         0: out_xfer[ep] = 1'b1;
         1: out_dis[ep] = 1'b1;
         2: out_setup[ep] = 1'b1;
         3: out_tok[ep] = 1'b1;
         4: in_tok[ep] = 1'b1;
         5: in_xfer[ep] = 1'b1;
         6: in_dis[ep] = 1'b1;
         7: in_tmo[ep] = 1'b1;
         default: ;
      endcase
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      {out_xfer, out_dis, out_setup, out_tok, in_tok, in_xfer, in_dis, in_tmo} = '0;
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      fire(-1, 0, 1'b1, a, d);
   endtask

   task automatic ev(input int kind, input int ep);
      fire(kind, ep, 1'b0, 5'd0, 32'd0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      {out_xfer, out_dis, out_setup, out_tok, in_tok, in_xfer, in_dis, in_tmo} = '0;
      ep_en = '1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      for (int e = 0; e < NE; e++) begin exp_out[e] = 0; exp_in[e] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all("R1");
      @(negedge clk) rst_n = 1'b1;
      check_all("R1");

      // R2: every plain event on every endpoint; timeout only on ep0 (control)
      for (int e = 0; e < NE; e++) begin
         ev(0, e); exp_out[e][0] = 1;
         ev(1, e); exp_out[e][1] = 1;
         ev(5, e); exp_in[e][0] = 1;
         ev(6, e); exp_in[e][1] = 1;
         ev(7, e); if (e == 0) exp_in[e][3] = 1;  // R9 non-control ignores timeout
      end
      check_all("R2");

      // R3: write zeros leaves all flags
      for (int a = 0; a < 2 * NE; a++) wr(5'(a), 32'd0);
      check_all("R3");

      // R3/R5: clear bit 1 everywhere, then IN bit 0 then rest
      for (int e = 0; e < NE; e++) begin
         wr(5'(e), 32'h2);      exp_out[e][1] = 0;
         wr(5'(NE + e), 32'h2); exp_in[e][1] = 0;
      end
      check_all("R3");
      for (int e = 0; e < NE; e++) begin
         wr(5'(NE + e), 32'hFFFF_FFFF); exp_in[e] = 0;
      end
      check_all("R5");
      for (int e = 0; e < NE; e++) begin
         wr(5'(e), 32'h1); exp_out[e] = 0;
      end
      check_all("R5");

      // R4: set and clear in same cycle; other bits in the write still clear
      ev(1, 3);
      fire(0, 3, 1'b1, 5'd3, 32'h3);
      rd(5'd3, d); chk("R4", "set wins", d, 32'h1);
      fire(5, 6, 1'b1, 5'(NE + 6), 32'h1);
      rd(5'(NE + 6), d); chk("R4", "in set wins", d, 32'h1);
      wr(5'd3, 32'h1); wr(5'(NE + 6), 32'h1);
      rd(5'd16, d); chk("R5", "summary clear", d, 32'h0);

      // R6/R7: two SETUPs then OUT token
      ev(2, 0); rd(5'd0, d); chk("R6", "no done mid-run", d, 32'h0);
      ev(2, 0); rd(5'd0, d); chk("R6", "no done mid-run 2", d, 32'h0);
      ev(3, 0); rd(5'd0, d); chk("R6", "done after token", d, 32'h08);
      wr(5'd0, 32'h08);
      // four in a row -> b2b on the fourth only
      ev(2, 0); ev(2, 0); ev(2, 0);
      rd(5'd0, d); chk("R7", "three not b2b", d, 32'h0);
      ev(2, 0); rd(5'd0, d); chk("R7", "fourth b2b", d, 32'h40);
      ev(4, 0); rd(5'd0, d); chk("R6", "done via IN token", d, 32'h48);
      wr(5'd0, 32'h48);
      // token restarts count
      ev(2, 0); ev(2, 0); ev(2, 0); ev(3, 0); ev(2, 0);
      rd(5'd0, d); chk("R7", "count restarted", d, 32'h08);
      ev(3, 0); wr(5'd0, 32'hFF);
      rd(5'd0, d); chk("R3", "cleared", d, 32'h0);
      // token without prior SETUP: no done
      ev(3, 0); rd(5'd0, d); chk("R6", "no setup no done", d, 32'h0);

      // R8: OUT token while disabled
      ep_en[0] = 1'b0; ep_en[2] = 1'b0;
      ev(3, 0); rd(5'd0, d); chk("R8", "tokd ctrl", d, 32'h10);
      ev(3, 2); rd(5'd2, d); chk("R8", "tokd non-ctrl", d, 32'h0);
      ep_en = '1; wr(5'd0, 32'h10);
      ev(3, 0); rd(5'd0, d); chk("R8", "enabled no tokd", d, 32'h0);

      // R9: non-control endpoint ignores SETUP run
      for (int k = 0; k < 5; k++) ev(2, 3);
      ev(4, 3); ev(3, 3);
      rd(5'd3, d); chk("R9", "non-ctrl setup", d, 32'h0);
      rd(5'd16, d); chk("R9", "summary quiet", d, 32'h0);

      // R10: summary and unmapped addresses
      ev(0, 5); ev(7, 0);
      wr(5'd16, 32'hFFFF_FFFF);
      rd(5'd16, d); chk("R10", "summary write ignored", d, 32'h0020_0001);
      wr(5'd20, 32'hFFFF_FFFF);
      rd(5'd20, d); chk("R10", "unmapped reads zero", d, 32'h0);
      rd(5'd5, d);  chk("R10", "out5 kept", d, 32'h1);
      rd(5'(NE), d); chk("R10", "in0 kept", d, 32'h8);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule